// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and passes data across in one direction at a time. Each direction has its own capture register with its own rising-edge clock. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. Sampling happens on every edge of that register's clock, whatever the output controls are doing.

An active-low output enable and a direction input decide which bus, if either, the block drives. When the outputs are disabled, the block isolates both buses and drives neither. For each direction a select input picks what the driven bus receives: the live value on the opposite bus, or the value held in that direction's register.

Each bus is modelled as three separate vectors: an input, an output and a per-bit output enable. Pad-level tri-state buffers sit outside the block. The block has no streaming traffic, so every pin is a plain level or clock with no valid/ready handshake. Both registers clear through one active-low asynchronous reset.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On every rising edge of `cap_a_clk`, the A-to-B register loads `a_in`, whatever the values of `out_en_n`, `to_b`, `ab_stored` and `ba_stored`.
- R2: On every rising edge of `cap_b_clk`, the B-to-A register loads `b_in`, whatever the values of the four control inputs.
- R3: While `rst_n` is low, both registers are zero and `a_oe` and `b_oe` are all zeros.
- R4: With `out_en_n` high, `a_oe` and `b_oe` are all zeros. With no clock edge, both registers keep their contents.
- R5: With `out_en_n` low, the `to_b` input picks the driven bus. `to_b` = 0 makes `a_oe` all ones and `b_oe` all zeros; `to_b` = 1 makes `b_oe` all ones and `a_oe` all zeros.
- R6: While A is driven, `a_out` equals `b_in` when `ba_stored` = 0, and equals the B-to-A register when `ba_stored` = 1.
- R7: While B is driven, `b_out` equals `a_in` when `ab_stored` = 0, and equals the A-to-B register when `ab_stored` = 1.
- R8: `a_oe` and `b_oe` are never nonzero at the same time.
- R9: Whenever a bus's enable vector is all zeros, that bus's output vector is zero.
- R10: When both clocks rise together, both registers load, while a bus is driven or while both are isolated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of both registers and the enables |
| cap_a_clk | input | 1 | Rising edge loads `a_in` into the A-to-B register |
| cap_b_clk | input | 1 | Rising edge loads `b_in` into the B-to-A register |
| out_en_n | input | 1 | Active-low output enable; high isolates both buses |
| to_b | input | 1 | 0 drives bus A, 1 drives bus B (when enabled) |
| ab_stored | input | 1 | Source for bus B: 0 live `a_in`, 1 A-to-B register |
| ba_stored | input | 1 | Source for bus A: 0 live `b_in`, 1 B-to-A register |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value to drive onto bus A |
| a_oe | output | W | Per-bit drive enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value to drive onto bus B |
| b_oe | output | W | Per-bit drive enable for bus B |

## Verification
A corrupted register stays hidden until that direction is enabled with its select at stored. From then on the wrong value shows on the driven bus's output immediately, with no extra cycle. For this reason the bench reads back every capture by enabling the matching direction with the stored select. A decode fault in the enable logic shows at once on `a_oe` or `b_oe`, for whichever combination of output enable and direction triggers it. The bench therefore walks all sixteen control combinations against its own model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Which bus the block currently drives.
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  // Path indices: path 0 carries A toward B, path 1 carries B toward A.
  localparam int unsigned PATH_AB = 0;
  localparam int unsigned PATH_BA = 1;
  localparam int unsigned N_PATHS = 2;

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         cap_clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // Set by the first capture edge after reset, so the check below never
  // looks back to a value sampled before or during reset.
  logic armed;
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1/R2: the register holds what its bus carried at the previous edge.
  a_r1_capture_follows: assert property (@(posedge cap_clk) disable iff (!rst_n)
    armed |-> (q == $past(d)));

  // R3: register is zero while in reset.
  always_comb begin
    if (rst_n === 1'b0) a_r3_reset_clear: assert (q == '0);
  end

endmodule

// File: rtl/xcvr_dir_decode.sv
module xcvr_dir_decode
  import xcvr_pkg::*;
(
  input  logic   rst_n,
  input  logic   out_en_n,
  input  logic   to_b,
  output drive_e drive
);

  always_comb begin
    if (!rst_n || out_en_n) drive = DRV_NONE;
    else if (to_b)          drive = DRV_B;
    else                    drive = DRV_A;
  end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned W = 8
) (
  input  logic         en,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout,
  output logic [W-1:0] oe
);

  logic [W-1:0] pick;

  always_comb begin
    pick = use_stored ? stored : live;
    dout = en ? pick : '0;
    oe   = {W{en}};
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic         cap_a_clk,
  input  logic         cap_b_clk,
  input  logic         out_en_n,
  input  logic         to_b,
  input  logic         ab_stored,
  input  logic         ba_stored,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  drive_e drive;

  logic [N_PATHS-1:0] p_clk;
  logic [N_PATHS-1:0] p_sel;
  logic [N_PATHS-1:0] p_en;
  logic [W-1:0]       p_src  [N_PATHS];
  logic [W-1:0]       p_reg  [N_PATHS];
  logic [W-1:0]       p_out  [N_PATHS];
  logic [W-1:0]       p_oe   [N_PATHS];

  xcvr_dir_decode i_decode (
    .rst_n    (rst_n),
    .out_en_n (out_en_n),
    .to_b     (to_b),
    .drive    (drive)
  );

  // Path AB: captures A, drives B.  Path BA: captures B, drives A.
  always_comb begin
    p_clk[PATH_AB] = cap_a_clk;
    p_clk[PATH_BA] = cap_b_clk;
    p_sel[PATH_AB] = ab_stored;
    p_sel[PATH_BA] = ba_stored;
    p_en[PATH_AB]  = (drive == DRV_B);
    p_en[PATH_BA]  = (drive == DRV_A);
    p_src[PATH_AB] = a_in;
    p_src[PATH_BA] = b_in;
  end

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    xcvr_capture #(.W(W)) i_cap (
      .rst_n   (rst_n),
      .cap_clk (p_clk[p]),
      .d       (p_src[p]),
      .q       (p_reg[p])
    );

    xcvr_path_mux #(.W(W)) i_mux (
      .en         (p_en[p]),
      .use_stored (p_sel[p]),
      .live       (p_src[p]),
      .stored     (p_reg[p]),
      .dout       (p_out[p]),
      .oe         (p_oe[p])
    );
  end

  always_comb begin
    b_out = p_out[PATH_AB];
    b_oe  = p_oe[PATH_AB];
    a_out = p_out[PATH_BA];
    a_oe  = p_oe[PATH_BA];
  end

  // Port-level checks, active once reset has a known value.
  always_comb begin
    if (rst_n === 1'b1) begin
      // R8: never drive both buses.
      a_r8_single_bus: assert (!((|a_oe) && (|b_oe)));
      // R4: isolation leaves both buses undriven.
      a_r4_isolate: assert (!out_en_n || ((a_oe == '0) && (b_oe == '0)));
      // R9: an undriven bus outputs zero.
      a_r9_quiet_a: assert ((a_oe != '0) || (a_out == '0));
      a_r9_quiet_b: assert ((b_oe != '0) || (b_out == '0));
      // R7: stored select on B shows the A-to-B register.
      a_r7_stored_b: assert (!((|b_oe) && ab_stored) || (b_out == p_reg[PATH_AB]));
      // R6: live select on A shows the B input.
      a_r6_live_a: assert (!((|a_oe) && !ba_stored) || (a_out == b_in));
    end else if (rst_n === 1'b0) begin
      a_r3_no_drive: assert ((a_oe == '0) && (b_oe == '0));
    end
  end

endmodule

// File: tb/test_bus_xcvr_reg.sv
module test_bus_xcvr_reg;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n, cap_a_clk, cap_b_clk, out_en_n, to_b, ab_stored, ba_stored;
  logic [W-1:0] a_in, b_in, a_out, a_oe, b_out, b_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ab, m_ba;  // bench model of the two registers

  always #5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) i_bus_xcvr_reg (
    .rst_n(rst_n), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
    .out_en_n(out_en_n), .to_b(to_b), .ab_stored(ab_stored), .ba_stored(ba_stored),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic set_ctl(input logic oen, input logic tb_, input logic sab, input logic sba);
    @(negedge clk);
    out_en_n = oen; to_b = tb_; ab_stored = sab; ba_stored = sba;
    #1;
  endtask

  // Rising edges on the chosen capture clocks, mid-cycle; model updated alongside.
  task automatic pulse(input bit ea, input bit eb);
    @(negedge clk);
    cap_a_clk = ea; cap_b_clk = eb;
    if (ea) m_ab = a_in;
    if (eb) m_ba = b_in;
    @(posedge clk);
    cap_a_clk = 1'b0; cap_b_clk = 1'b0;
    #1;
  endtask

  // Read both registers back through the normal outputs.
  task automatic read_regs(input string req);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
    chk(req, b_out, m_ab);
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    chk(req, a_out, m_ba);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; out_en_n = 1'b0; to_b = 1'b0; ab_stored = 1'b1; ba_stored = 1'b1;
    cap_a_clk = 1'b0; cap_b_clk = 1'b0; a_in = 8'h5A; b_in = 8'hA5;
    m_ab = '0; m_ba = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 a_oe in reset", a_oe, '0);
    chk("R3 b_oe in reset", b_oe, '0);
    @(negedge clk) rst_n = 1'b1;
    read_regs("R3 regs cleared");
  endtask

  task automatic t_isolation;
    set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
    a_in = 8'h3C; b_in = 8'hC3;
    pulse(1'b1, 1'b0);
    #1;
    chk("R4 a_oe isolated", a_oe, '0);
    chk("R9 a_out quiet", a_out, '0);
    chk("R9 b_out quiet", b_out, '0);
    pulse(1'b0, 1'b1);
    a_in = 8'hFF; b_in = 8'h00;   // no edge: must not be stored
    repeat (2) @(posedge clk);
    read_regs("R4 hold/capture while isolated R1 R2");
  endtask

  task automatic t_capture_while_driving;
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);   // A driven, B is input
    a_in = 8'h11; b_in = 8'h77;
    pulse(1'b0, 1'b1);
    chk("R6 live b to a", a_out, 8'h77);
    set_ctl(1'b0, 1'b1, 1'b1, 1'b1);   // B driven, capture A with stored select
    a_in = 8'h99;
    pulse(1'b1, 1'b0);
    chk("R1 stored a shown on b", b_out, 8'h99);
    read_regs("R2 capture under drive");
  endtask

  task automatic t_simultaneous;
    a_in = 8'h24; b_in = 8'h42;
    set_ctl(1'b0, 1'b0, 1'b0, 1'b1);
    pulse(1'b1, 1'b1);
    read_regs("R10 both edges while driving");
    set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
    a_in = 8'hE1; b_in = 8'h1E;
    pulse(1'b1, 1'b1);
    read_regs("R10 both edges while isolated");
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 16; k++) begin
      logic oen, tb_, sab, sba;
      logic [W-1:0] ea_oe, eb_oe, ea_out, eb_out;
      {oen, tb_, sab, sba} = k[3:0];
      a_in = 8'h30 + 8'(k); b_in = 8'hC0 + 8'(k);
      pulse(k[0], k[1]);
      set_ctl(oen, tb_, sab, sba);
      ea_oe = (!oen && !tb_) ? '1 : '0;
      eb_oe = (!oen &&  tb_) ? '1 : '0;
      ea_out = (ea_oe != '0) ? (sba ? m_ba : b_in) : '0;
      eb_out = (eb_oe != '0) ? (sab ? m_ab : a_in) : '0;
      chk("R5 a_oe", a_oe, ea_oe);
      chk("R5 b_oe", b_oe, eb_oe);
      chk("R6 R9 a_out", a_out, ea_out);
      chk("R7 R9 b_out", b_out, eb_out);
      checks++;
      if ((|a_oe) && (|b_oe)) begin
        errors++;
        $display("FAIL R8 a_oe=%h b_oe=%h expected one zero", a_oe, b_oe);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_isolation();
    t_capture_while_driving();
    t_simultaneous();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule